// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block keeps one load-linked reservation for each hardware thread of a small multithreaded core. A reservation is a valid flag plus a physical address rounded down to a 16-byte granule. A load-linked request arms the reservation of its own thread. A store-conditional request from that thread is then checked against it. The block decides whether the store may go to memory, and it returns a 2-bit status code that the core writes back.

Requests arrive on a valid/ready channel. The registered response leaves on a valid/ready channel of its own. The response register holds one entry, so `req_ready` is high whenever that register is empty or is being drained in the same cycle: `req_ready = !rsp_valid || rsp_ready`. When the consumer holds `rsp_ready` low, the response stays unchanged and no further request is accepted.

For each thread the block also counts store-conditionals that fail in a row. It raises a one-cycle warning on every tenth consecutive failure. At a fixed limit it sets a fatal livelock flag that only a reset clears. The warning and fatal pins are plain status outputs.

Top module: `llsc_resv_monitor`

## Requirements
- R1: After synchronous reset, `rsp_valid`, every `warn` bit and every `fatal` bit are 0 and `req_ready` is 1. No reservation is armed, so a store-conditional fails.
- R2: A load-linked request (`req_kind`=0) arms its thread's reservation with `req_addr` rounded down to 16 bytes. Its response carries `rsp_issue`=1 and status 1.
- R3: A cacheable store-conditional (`req_kind`=1, `req_uncached`=0) succeeds when the thread's flag is set and its address matches the stored one with bits [3:0] ignored. On success it returns status 1 (OK) with `rsp_issue`=1 and clears the flag, so a second store-conditional fails.
- R4: A cacheable store-conditional on a thread with no armed reservation returns status 0 (FAIL) with `rsp_issue`=0.
- R5: A cacheable store-conditional whose granule differs from the reserved one fails with status 0 and `rsp_issue`=0, and it clears the flag.
- R6: Each thread, selected by `req_tid`, has its own reservation. Requests from one thread never change the reservation of another thread.
- R7: An uncacheable store-conditional returns status 2 (no writeback) with `rsp_issue`=1. It leaves the reservation untouched and leaves the failure count untouched.
- R8: A new load-linked on a thread replaces the address of any reservation that thread already holds and re-arms the flag.
- R9: Each thread counts its consecutive failed store-conditionals. `warn[t]` pulses high in the same cycle as the response whose new count is a multiple of 10. A successful store-conditional resets the count to zero.
- R10: When a thread's count reaches 5000, `fatal[t]` goes high with that response and stays high until reset.
- R11: The response appears the cycle after the request is accepted. While `rsp_ready` is 0 the response holds steady and `req_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_kind | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_uncached | input | 1 | Store-conditional targets uncacheable space |
| req_tid | input | 2 | Requesting thread |
| req_addr | input | 32 | Physical address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_issue | output | 1 | Forward the access to memory |
| rsp_status | output | 2 | 0 fail, 1 ok, 2 no writeback |
| rsp_tid | output | 2 | Thread of the response |
| warn | output | 4 | Per-thread pulse on every tenth consecutive failure |
| fatal | output | 4 | Per-thread sticky livelock flag |

## Verification
Every result is due exactly one clock edge after the request is accepted. This covers the response fields, the `warn` pulse and a new `fatal` bit. Reservation changes made at that same edge govern the very next request. The bench drives on the falling edge, lets one rising edge accept the request, drops `req_valid`, and samples at the following falling edge. That is the one cycle in which the registered response is valid. Stall checks hold `rsp_ready` low and sample over several falling edges to confirm that the response and `req_ready` do not move.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    ST_FAIL = 2'd0,
    ST_OK   = 2'd1,
    ST_NOWB = 2'd2
  } llsc_status_e;

  localparam logic KIND_LL = 1'b0;
  localparam logic KIND_SC = 1'b1;
endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_evt,
  input  logic             drop_evt,
  input  logic [TAG_W-1:0] arm_tag,
  input  logic [TAG_W-1:0] probe_tag,
  output logic             hit
);
  logic             flag_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      tag_q  <= '0;
    end else if (arm_evt) begin
      flag_q <= 1'b1;
      tag_q  <= arm_tag;
    end else if (drop_evt) begin
      flag_q <= 1'b0;
    end
  end

  assign hit = flag_q && (tag_q == probe_tag);

  // R2
  arm_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    arm_evt |=> flag_q);
endmodule

// File: rtl/llsc_fail_counter.sv
module llsc_fail_counter #(
  parameter int FAIL_LIMIT  = 5000,
  parameter int WARN_PERIOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic fail_evt,
  input  logic clear_evt,
  output logic warn_o,
  output logic fatal_o
);
  localparam int CNT_W = $clog2(FAIL_LIMIT + 1);
  localparam int DEC_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(FAIL_LIMIT);
  localparam logic [DEC_W-1:0] DEC_TOP = DEC_W'(WARN_PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [DEC_W-1:0] dec_q;
  logic             warn_q, fatal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      dec_q   <= '0;
      warn_q  <= 1'b0;
      fatal_q <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      if (clear_evt) begin
        cnt_q <= '0;
        dec_q <= '0;
      end else if (fail_evt) begin
        if (cnt_q != LIMIT_V) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LIMIT_V - 1'b1) fatal_q <= 1'b1;
        if (dec_q == DEC_TOP) begin
          dec_q  <= '0;
          warn_q <= 1'b1;
        end else begin
          dec_q <= dec_q + 1'b1;
        end
      end
    end
  end

  assign warn_o  = warn_q;
  assign fatal_o = fatal_q;

  // R10
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fatal_q |=> fatal_q);
  // R9
  warn_needs_fail_chk: assert property (@(posedge clk) disable iff (rst)
    fail_evt && !clear_evt && dec_q != DEC_TOP |=> !warn_q);
endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor
  import llsc_pkg::*;
#(
  parameter int THREADS     = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int FAIL_LIMIT  = 5000,
  parameter int WARN_PERIOD = 10,
  localparam int TID_W      = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_kind,
  input  logic               req_uncached,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_issue,
  output logic [1:0]         rsp_status,
  output logic [TID_W-1:0]   rsp_tid,
  output logic [THREADS-1:0] warn,
  output logic [THREADS-1:0] fatal
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic               accept;
  logic [TAG_W-1:0]   req_tag;
  logic [THREADS-1:0] hit_vec, arm_vec, drop_vec, fail_vec, ok_vec;
  logic               hit_sel, is_ll, is_csc;
  logic               nxt_issue;
  llsc_status_e       nxt_status;

  logic               rsp_valid_q, rsp_issue_q;
  llsc_status_e       rsp_status_q;
  logic [TID_W-1:0]   rsp_tid_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign req_tag   = req_addr[ADDR_W-1:GRAN_BITS];
  assign hit_sel   = hit_vec[req_tid];
  assign is_ll     = accept && (req_kind == KIND_LL);
  assign is_csc    = accept && (req_kind == KIND_SC) && !req_uncached;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic mine;
    assign mine        = (req_tid == TID_W'(t));
    assign arm_vec[t]  = is_ll && mine;
    assign drop_vec[t] = is_csc && mine;
    assign fail_vec[t] = drop_vec[t] && !hit_sel;
    assign ok_vec[t]   = drop_vec[t] && hit_sel;

    llsc_resv_slot #(.TAG_W(TAG_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .arm_evt  (arm_vec[t]),
      .drop_evt (drop_vec[t]),
      .arm_tag  (req_tag),
      .probe_tag(req_tag),
      .hit      (hit_vec[t])
    );

    llsc_fail_counter #(.FAIL_LIMIT(FAIL_LIMIT), .WARN_PERIOD(WARN_PERIOD)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .fail_evt (fail_vec[t]),
      .clear_evt(ok_vec[t]),
      .warn_o   (warn[t]),
      .fatal_o  (fatal[t])
    );
  end

  always_comb begin
    nxt_status = ST_OK;
    nxt_issue  = 1'b1;
    if (req_kind == KIND_SC) begin
      if (req_uncached) begin
        nxt_status = ST_NOWB;
      end else if (!hit_sel) begin
        nxt_status = ST_FAIL;
        nxt_issue  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q  <= 1'b0;
      rsp_issue_q  <= 1'b0;
      rsp_status_q <= ST_FAIL;
      rsp_tid_q    <= '0;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_issue_q  <= nxt_issue;
      rsp_status_q <= nxt_status;
      rsp_tid_q    <= req_tid;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_issue  = rsp_issue_q;
  assign rsp_status = rsp_status_q;
  assign rsp_tid    = rsp_tid_q;

  // R4
  fail_not_issued_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_status == 2'd0 |-> !rsp_issue);
  // R9
  warn_with_fail_chk: assert property (@(posedge clk) disable iff (rst)
    (|warn) |-> rsp_valid && rsp_status == 2'd0);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_issue));
endmodule

// File: tb/llsc_resv_monitor_tb.sv
module llsc_resv_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 17;

  typedef struct packed {
    logic        kind;
    logic        unc;
    logic [1:0]  tid;
    logic [31:0] addr;
    logic [1:0]  st;
    logic        iss;
  } vec_t;

  // kind 0 = LL, 1 = SC; status 0 fail, 1 ok, 2 no writeback
  localparam vec_t TBL [NROWS] = '{
    '{1'b1, 1'b0, 2'd0, 32'h0000_0100, 2'd0, 1'b0},  // R4 nothing armed
    '{1'b0, 1'b0, 2'd0, 32'h0000_1234, 2'd1, 1'b1},  // R2
    '{1'b1, 1'b0, 2'd0, 32'h0000_123C, 2'd1, 1'b1},  // R3 low bits ignored
    '{1'b1, 1'b0, 2'd0, 32'h0000_1230, 2'd0, 1'b0},  // R3 flag consumed
    '{1'b0, 1'b0, 2'd1, 32'h0000_2000, 2'd1, 1'b1},
    '{1'b0, 1'b0, 2'd2, 32'h0000_3000, 2'd1, 1'b1},
    '{1'b1, 1'b0, 2'd1, 32'h0000_2010, 2'd0, 1'b0},  // R5 mismatch
    '{1'b1, 1'b0, 2'd1, 32'h0000_2000, 2'd0, 1'b0},  // R5 flag cleared
    '{1'b1, 1'b0, 2'd2, 32'h0000_3008, 2'd1, 1'b1},  // R6 other thread intact
    '{1'b0, 1'b0, 2'd3, 32'h0000_4000, 2'd1, 1'b1},
    '{1'b1, 1'b1, 2'd3, 32'h0000_9999, 2'd2, 1'b1},  // R7 uncached
    '{1'b1, 1'b0, 2'd3, 32'h0000_4004, 2'd1, 1'b1},  // R7 reservation kept
    '{1'b0, 1'b0, 2'd0, 32'h0000_5000, 2'd1, 1'b1},
    '{1'b0, 1'b0, 2'd0, 32'h0000_6000, 2'd1, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h0000_5000, 2'd0, 1'b0},  // R8 old address gone
    '{1'b0, 1'b0, 2'd0, 32'h0000_6000, 2'd1, 1'b1},
    '{1'b1, 1'b0, 2'd0, 32'h0000_600F, 2'd1, 1'b1}   // R8 new address
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_kind = 1'b0, req_uncached = 1'b0, rsp_ready = 1'b1;
  logic [1:0]  req_tid = '0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_issue;
  logic [1:0]  rsp_status, rsp_tid;
  logic [3:0]  warn, fatal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [1:0] got_st;
  logic       got_iss, got_val;
  logic [3:0] got_warn, got_fatal;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_resv_monitor dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_uncached(req_uncached), .req_tid(req_tid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_issue(rsp_issue), .rsp_status(rsp_status), .rsp_tid(rsp_tid),
    .warn(warn), .fatal(fatal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic k, input logic u, input logic [1:0] t, input logic [31:0] a);
    @(negedge clk);
    req_kind = k; req_uncached = u; req_tid = t; req_addr = a; req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    got_val = rsp_valid; got_st = rsp_status; got_iss = rsp_issue;
    got_warn = warn; got_fatal = fatal;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<200000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 warn", warn, 0);
    chk("R1 fatal", fatal, 0);

    for (int i = 0; i < NROWS; i++) begin
      send(TBL[i].kind, TBL[i].unc, TBL[i].tid, TBL[i].addr);
      chk($sformatf("R11 row%0d valid", i), got_val, 1);
      chk($sformatf("R2-table row%0d status", i), got_st, TBL[i].st);
      chk($sformatf("R3 row%0d issue", i), got_iss, TBL[i].iss);
      chk($sformatf("R9 row%0d warn", i), got_warn, 0);
    end

    // R9 warning cadence on thread 2 (count 0 after last success)
    for (int n = 1; n <= 10; n++) begin
      send(1'b1, 1'b0, 2'd2, 32'h0000_7000);
      chk($sformatf("R9 fail%0d warn", n), got_warn, (n == 10) ? 4'b0100 : 4'b0000);
    end
    send(1'b1, 1'b1, 2'd2, 32'h0000_7000); // R7 counter untouched
    for (int n = 11; n <= 20; n++) begin
      send(1'b1, 1'b0, 2'd2, 32'h0000_7000);
      chk($sformatf("R7 R9 fail%0d warn", n), got_warn, (n == 20) ? 4'b0100 : 4'b0000);
    end
    send(1'b1, 1'b0, 2'd2, 32'h0000_7000); // count 21
    send(1'b0, 1'b0, 2'd2, 32'h0000_7000);
    send(1'b1, 1'b0, 2'd2, 32'h0000_7000); // success resets count
    chk("R9 success status", got_st, 1);
    for (int n = 1; n <= 10; n++) begin
      send(1'b1, 1'b0, 2'd2, 32'h0000_7000);
      chk($sformatf("R9 after reset fail%0d warn", n), got_warn, (n == 10) ? 4'b0100 : 4'b0000);
    end

    // R10 fatal at 5000 on thread 3
    for (int n = 1; n <= 4999; n++) send(1'b1, 1'b0, 2'd3, 32'h0000_8000);
    chk("R10 before limit", got_fatal, 4'b0000);
    send(1'b1, 1'b0, 2'd3, 32'h0000_8000);
    chk("R10 at limit", got_fatal, 4'b1000);
    send(1'b0, 1'b0, 2'd3, 32'h0000_8000);
    send(1'b1, 1'b0, 2'd3, 32'h0000_8000);
    chk("R10 success status", got_st, 1);
    chk("R10 sticky", got_fatal, 4'b1000);

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    send(1'b1, 1'b1, 2'd1, 32'h0000_0040);
    chk("R11 stall valid", got_val, 1);
    chk("R11 stall ready low", req_ready, 0);
    req_kind = 1'b0; req_uncached = 1'b0; req_tid = 2'd1; req_addr = 32'h0000_A000; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held status", rsp_status, 2);
    chk("R11 held ready", req_ready, 0);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 drained", rsp_valid, 0);
    // the held load-linked was never accepted: thread 1 still unarmed
    send(1'b1, 1'b0, 2'd1, 32'h0000_A000);
    chk("R11 R6 no accept during stall", got_st, 0);

    // R1 reset clears fatal and reservations
    send(1'b0, 1'b0, 2'd0, 32'h0000_B000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 fatal cleared", fatal, 0);
    send(1'b1, 1'b0, 2'd0, 32'h0000_B000);
    chk("R1 reservation cleared", got_st, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule